// File: doc/BRIEF.md
# Multi-Band Threshold Output Classifier

This block turns digitised analog output measurements into Boolean results. Each output channel holds a small set of threshold words. Together they split the measurement range into ordered bands. A programmable label bit for every band decides what the channel reports when a measurement lands in that band. Because every band carries its own label, a single measurement can give a monotonic function such as AND or OR, a window function such as XOR, or the alternating pattern of an adder sum.

Each threshold is taken from a configuration voltage word. Per threshold slot, the block uses that word either as it is or multiplied by a shared unsigned fixed-point scale factor, so thresholds can follow the configuration at run time. The slots of a channel may be loaded in any order. The band is found by counting how many active thresholds the measurement reaches, so no sorting is needed. All channels take a new sample on a shared valid strobe. One cycle later they present registered results with a matching valid pulse.

Top module: `band_classifier`

## Requirements
- R1: While reset (`rst_n` low) is held, `outValid` and every bit of `outBit` are 0.
- R2: A sample presented with `measValid` high at a rising clock edge gives `outValid` high for exactly the following cycle, with `outBit` updated at that edge; with `measValid` low, `outValid` is low in the next cycle.
- R3: When `measValid` is low at an edge, `outBit` keeps its previous value whatever the other inputs do.
- R4: For channel c, let N = `thrCount[c*2+:2]` and let the active thresholds be slots 0..N-1. The band index from the top is p = N minus the number of active thresholds that the measurement `measWord[c*14+:14]` is greater than or equal to. The result is `bandLabel[c*4+p]`, so bit 0 labels the top band.
- R5: Bands are half-open: a measurement equal to a threshold counts as reaching it and falls in the band above.
- R6: The result does not depend on the order in which threshold values are placed in the active slots.
- R7: Slot i of channel c holds the voltage word `cfgVolt[(c*3+i)*14+:14]` in unsigned millivolts. With `scaleEn[c*3+i]` low the threshold is that word. With it high the threshold is floor(word × `scaleFactor` / 8192), where `scaleFactor` is unsigned Q3.13.
- R8: A scaled threshold above 11200 is clamped to 11200.
- R9: With N = 0 the result is `bandLabel[c*4]` for any measurement.
- R10: Slots at or beyond N have no effect on the result, and channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| measValid | input | 1 | Sample strobe shared by all channels |
| measWord | input | 28 | Measurement per channel, 14 bits each, unsigned mV |
| cfgVolt | input | 84 | Configuration voltage per channel and slot, 14 bits each |
| scaleEn | input | 6 | Per slot: 1 selects the scaled voltage as threshold |
| scaleFactor | input | 16 | Shared scale factor, unsigned Q3.13 |
| thrCount | input | 4 | Active threshold count per channel, 2 bits each |
| bandLabel | input | 8 | Band output labels per channel, 4 bits each, bit 0 = top band |
| outBit | output | 2 | Registered classification per channel |
| outValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench places measurements exactly on a threshold and one millivolt either side of it. A design with an inclusive upper bound or an exclusive lower bound flips the result only at those points. It loads the same threshold set in sorted and shuffled slot orders, which catches a design that assumes descending slots and reads the wrong band label. Scale factors near 4.0 push products past the clamp, which exposes wrap-around in the scaled path. Random label patterns together with thresholds placed in unused slots, counts of zero and a hold cycle with changed inputs show label mis-indexing, leakage from inactive slots and results that change without a strobe.

// File: rtl/band_pkg.sv
package band_pkg;

  localparam int DEF_NUM_CH  = 2;
  localparam int DEF_MAX_THR = 3;
  localparam int DEF_VW      = 14;
  localparam int DEF_SW      = 16;
  localparam int DEF_FRAC    = 13;
  localparam int DEF_VMAX    = 11200;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load new classification into the result register
    logic hold;      // keep the previous result
  } band_ctrl_t;

endpackage

// File: rtl/band_scaler.sv
module band_scaler #(
  parameter int VW   = 14,
  parameter int SW   = 16,
  parameter int FRAC = 13,
  parameter int VMAX = 11200
) (
  input  logic [VW-1:0] volt,
  input  logic [SW-1:0] scale,
  output logic [VW-1:0] scaled
);
  localparam int PW = VW + SW;

  logic [PW-1:0] product;
  logic [PW-1:0] shifted;

  always_comb begin
    product = PW'(volt) * PW'(scale);
    shifted = product >> FRAC;
    if (shifted > PW'(VMAX)) scaled = VW'(VMAX);
    else                     scaled = shifted[VW-1:0];
  end
endmodule

// File: rtl/band_ctrl.sv
module band_ctrl
  import band_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       measValid,
  output band_ctrl_t ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl.capture = measValid;
    ctrl.hold    = !measValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= measValid;
  end
endmodule

// File: rtl/band_datapath.sv
module band_datapath
  import band_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int MAX_THR = 3,
  parameter int VW      = 14,
  parameter int SW      = 16,
  parameter int FRAC    = 13,
  parameter int VMAX    = 11200,
  localparam int CW     = $clog2(MAX_THR + 1),
  localparam int LW     = MAX_THR + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  band_ctrl_t                 ctrl,
  input  logic [NUM_CH*VW-1:0]       measWord,
  input  logic [NUM_CH*MAX_THR*VW-1:0] cfgVolt,
  input  logic [NUM_CH*MAX_THR-1:0]  scaleEn,
  input  logic [SW-1:0]              scaleFactor,
  input  logic [NUM_CH*CW-1:0]       thrCount,
  input  logic [NUM_CH*LW-1:0]       bandLabel,
  output logic [NUM_CH-1:0]          outBit
);
  logic [NUM_CH-1:0] nextBit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [VW-1:0]      meas;
    logic [CW-1:0]      cnt;
    logic [LW-1:0]      labels;
    logic [MAX_THR-1:0] reached;
    logic [CW-1:0]      hitCnt;
    logic [CW-1:0]      bandIdx;

    assign meas   = measWord[c*VW +: VW];
    assign cnt    = thrCount[c*CW +: CW];
    assign labels = bandLabel[c*LW +: LW];

    for (genvar s = 0; s < MAX_THR; s++) begin : g_slot
      logic [VW-1:0] rawThr;
      logic [VW-1:0] scaledThr;
      logic [VW-1:0] thr;
      logic          active;

      assign rawThr = cfgVolt[(c*MAX_THR + s)*VW +: VW];

      band_scaler #(
        .VW(VW), .SW(SW), .FRAC(FRAC), .VMAX(VMAX)
      ) i_scaler (
        .volt  (rawThr),
        .scale (scaleFactor),
        .scaled(scaledThr)
      );

      assign thr        = scaleEn[c*MAX_THR + s] ? scaledThr : rawThr;
      assign active     = CW'(s) < cnt;
      assign reached[s] = active && (meas >= thr);
    end

    always_comb begin
      hitCnt = '0;
      for (int k = 0; k < MAX_THR; k++) hitCnt = hitCnt + CW'(reached[k]);
      bandIdx    = cnt - hitCnt;
      nextBit[c] = labels[bandIdx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outBit <= '0;
    else if (ctrl.capture) outBit <= nextBit;
  end
endmodule

// File: rtl/band_classifier.sv
module band_classifier
  import band_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int MAX_THR = DEF_MAX_THR,
  parameter int VW      = DEF_VW,
  parameter int SW      = DEF_SW,
  parameter int FRAC    = DEF_FRAC,
  parameter int VMAX    = DEF_VMAX,
  localparam int CW     = $clog2(MAX_THR + 1),
  localparam int LW     = MAX_THR + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         measValid,
  input  logic [NUM_CH*VW-1:0]         measWord,
  input  logic [NUM_CH*MAX_THR*VW-1:0] cfgVolt,
  input  logic [NUM_CH*MAX_THR-1:0]    scaleEn,
  input  logic [SW-1:0]                scaleFactor,
  input  logic [NUM_CH*CW-1:0]         thrCount,
  input  logic [NUM_CH*LW-1:0]         bandLabel,
  output logic [NUM_CH-1:0]            outBit,
  output logic                         outValid
);
  band_ctrl_t ctrl;

  band_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .measValid(measValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  band_datapath #(
    .NUM_CH(NUM_CH), .MAX_THR(MAX_THR), .VW(VW), .SW(SW),
    .FRAC(FRAC), .VMAX(VMAX)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .measWord   (measWord),
    .cfgVolt    (cfgVolt),
    .scaleEn    (scaleEn),
    .scaleFactor(scaleFactor),
    .thrCount   (thrCount),
    .bandLabel  (bandLabel),
    .outBit     (outBit)
  );
endmodule

// File: rtl/band_classifier_chk.sv
module band_classifier_chk #(
  parameter int NUM_CH  = 2,
  parameter int MAX_THR = 3,
  parameter int VW      = 14,
  parameter int SW      = 16,
  localparam int CW     = $clog2(MAX_THR + 1),
  localparam int LW     = MAX_THR + 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         measValid,
  input logic [NUM_CH*VW-1:0]         measWord,
  input logic [NUM_CH*MAX_THR*VW-1:0] cfgVolt,
  input logic [NUM_CH*MAX_THR-1:0]    scaleEn,
  input logic [SW-1:0]                scaleFactor,
  input logic [NUM_CH*CW-1:0]         thrCount,
  input logic [NUM_CH*LW-1:0]         bandLabel,
  input logic [NUM_CH-1:0]            outBit,
  input logic                         outValid
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    measValid |=> outValid);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !measValid |=> !outValid);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !measValid |=> $stable(outBit));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4
    top_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (measValid && thrCount[c*CW +: CW] == CW'(1) && !scaleEn[c*MAX_THR]
       && measWord[c*VW +: VW] >= cfgVolt[c*MAX_THR*VW +: VW])
      |=> outBit[c] == $past(bandLabel[c*LW]));

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (measValid && thrCount[c*CW +: CW] == '0)
      |=> outBit[c] == $past(bandLabel[c*LW]));
  end
endmodule

bind band_classifier band_classifier_chk #(
  .NUM_CH(NUM_CH), .MAX_THR(MAX_THR), .VW(VW), .SW(SW)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .measValid  (measValid),
  .measWord   (measWord),
  .cfgVolt    (cfgVolt),
  .scaleEn    (scaleEn),
  .scaleFactor(scaleFactor),
  .thrCount   (thrCount),
  .bandLabel  (bandLabel),
  .outBit     (outBit),
  .outValid   (outValid)
);

// File: tb/test_band_classifier.sv
module test_band_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NT  = 3;
  localparam int VW  = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             measValid = 1'b0;
  logic [NCH*VW-1:0]    measWord = '0;
  logic [NCH*NT*VW-1:0] cfgVolt = '0;
  logic [NCH*NT-1:0]    scaleEn = '0;
  logic [15:0]          scaleFactor = 16'h2000;
  logic [NCH*2-1:0]     thrCount = '0;
  logic [NCH*4-1:0]     bandLabel = '0;
  logic [NCH-1:0]       outBit;
  logic                 outValid;

  int testsRun = 0;
  int testsFailed = 0;

  band_classifier i_band_classifier (
    .clk(clk), .rst_n(rst_n), .measValid(measValid), .measWord(measWord),
    .cfgVolt(cfgVolt), .scaleEn(scaleEn), .scaleFactor(scaleFactor),
    .thrCount(thrCount), .bandLabel(bandLabel), .outBit(outBit),
    .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int thrOf(int c, int s);
    int v;
    longint p;
    v = int'(cfgVolt[(c*NT+s)*VW +: VW]);
    if (!scaleEn[c*NT+s]) return v;
    p = (longint'(v) * longint'(scaleFactor)) / 8192;
    if (p > 11200) p = 11200;
    return int'(p);
  endfunction

  function automatic logic expBit(int c);
    int n, hits, m;
    n = int'(thrCount[c*2 +: 2]);
    m = int'(measWord[c*VW +: VW]);
    hits = 0;
    for (int s = 0; s < n; s++) if (m >= thrOf(c, s)) hits++;
    return bandLabel[c*4 + (n - hits)];
  endfunction

  task automatic check(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic setSlot(int c, int s, int v, logic sc);
    cfgVolt[(c*NT+s)*VW +: VW] = VW'(v);
    scaleEn[c*NT+s] = sc;
  endtask

  // drive one sample, then check at the negedge after capture
  task automatic sample(string req);
    logic [NCH-1:0] exp;
    for (int c = 0; c < NCH; c++) exp[c] = expBit(c);
    measValid = 1'b1;
    @(negedge clk);
    measValid = 1'b0;
    check({req, " R2 valid"}, outValid, 1'b1);
    for (int c = 0; c < NCH; c++) check(req, outBit[c], exp[c]);
  endtask

  int pick;

  initial begin
    void'($urandom(32'd20240531));
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 valid", outValid, 1'b0);
    check("R1 bit0", outBit[0], 1'b0);
    check("R1 bit1", outBit[1], 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 single threshold, R5 equality
    thrCount = 4'b0101; bandLabel = 8'b0010_0010;
    bandLabel = 8'b0001_0001;
    setSlot(0, 0, 3279, 1'b0); setSlot(1, 0, 3279, 1'b0);
    measWord = {14'd3278, 14'd3279};
    sample("R5 equal/below");
    measWord = {14'd3280, 14'd0};
    sample("R4 single");

    // R4 window (XOR-like) unordered slots, R6
    thrCount = 4'b1010; bandLabel = 8'b0010_0010;
    setSlot(0, 0, 2000, 1'b0); setSlot(0, 1, 5000, 1'b0);
    setSlot(1, 0, 5000, 1'b0); setSlot(1, 1, 2000, 1'b0);
    measWord = {14'd3000, 14'd3000};
    sample("R6 window inside");
    measWord = {14'd5000, 14'd4999};
    sample("R5 upper bound");
    measWord = {14'd1999, 14'd2000};
    sample("R5 lower bound");

    // R4 three thresholds, alternating labels, shuffled on ch1
    thrCount = 4'b1111; bandLabel = 8'b0101_0101;
    setSlot(0, 0, 9000, 1'b0); setSlot(0, 1, 6000, 1'b0); setSlot(0, 2, 3000, 1'b0);
    setSlot(1, 0, 3000, 1'b0); setSlot(1, 1, 9000, 1'b0); setSlot(1, 2, 6000, 1'b0);
    for (int k = 0; k < 4; k++) begin
      measWord = {VW'(k*3000 + 100), VW'(k*3000 + 100)};
      sample("R6 three-band");
    end

    // R7 scaled threshold, R8 saturation
    thrCount = 4'b0101; bandLabel = 8'b0001_0001;
    scaleFactor = 16'h4000; // 2.0
    setSlot(0, 0, 1500, 1'b1); setSlot(1, 0, 11200, 1'b1);
    measWord = {14'd11200, 14'd2999};
    sample("R7 scaled / R8 clamp");
    measWord = {14'd11199, 14'd3000};
    sample("R7 scaled / R8 clamp");
    scaleFactor = 16'hFFFF;
    measWord = {14'd11200, 14'd11200};
    sample("R8 clamp max");

    // R9 zero count, R10 inactive slots
    thrCount = 4'b0100; bandLabel = 8'b0001_0110;
    setSlot(0, 0, 16000, 1'b0); setSlot(1, 1, 0, 1'b0); setSlot(1, 2, 0, 1'b0);
    setSlot(1, 0, 8000, 1'b0); scaleEn = '0;
    measWord = {14'd100, 14'd16383};
    sample("R9 zero count / R10 inactive");

    // R3 hold: change inputs without a strobe
    begin
      logic [NCH-1:0] prev;
      prev = outBit;
      bandLabel = ~bandLabel; measWord = ~measWord;
      @(negedge clk);
      check("R3 hold valid", outValid, 1'b0);
      check("R3 hold ch0", outBit[0], prev[0]);
      check("R3 hold ch1", outBit[1], prev[1]);
    end

    // random mix, R4 R6 R7 R10
    for (int it = 0; it < 400; it++) begin
      thrCount = 4'($urandom_range(0, 15));
      bandLabel = 8'($urandom);
      scaleFactor = 16'($urandom);
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < NT; s++)
          setSlot(c, s, int'($urandom_range(0, 11200)), 1'($urandom_range(0, 1)));
      for (int c = 0; c < NCH; c++) begin
        pick = int'($urandom_range(0, 3));
        if (pick == 3) measWord[c*VW +: VW] = VW'($urandom_range(0, 11200));
        else begin
          int t;
          t = thrOf(c, pick) + int'($urandom_range(0, 2)) - 1;
          if (t < 0) t = 0;
          measWord[c*VW +: VW] = VW'(t);
        end
      end
      sample("R4 random");
      if (it % 50 == 0) begin
        @(negedge clk);
        check("R2 idle", outValid, 1'b0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule